// File: doc/BRIEF.md
# Parallel ATA PIO Host Transfer Engine

This block is the host side of a parallel ATA register and data port running at the fastest programmed-I/O timing class. A client hands it one transfer at a time through a valid/ready request port: direction, a two-bit chip-select pair, a three-bit register address and, for writes, a 16-bit word. The engine drives the chip selects and address onto the bus, waits out the setup interval, and pulses the read or write strobe. On a write it drives and holds the data bus. On a read it captures the word the device presents. It then holds the address, releases the bus and reports completion with a one-cycle done pulse.

The device may stretch any strobe by pulling its ready line low. The engine passes that line through a synchronizer and keeps the strobe active until the line is seen high again. Read data is captured at the release point, so the sample moves later whenever the device stretches the strobe. A stall longer than a configurable bound ends the transfer with an error flag. Each minimum interval is a parameter in clock cycles. The defaults are rounded up from the nanosecond limits for a 100 MHz clock.

Top module: `ata_pio_host`

## Requirements
- R1: After reset both strobes are high, both chip-select outputs are high, the data bus output enable is low, done is low and the request port is ready.
- R2: Chip selects and address are valid for exactly T_ASETUP cycles (default 3) before a strobe goes low, and they do not change while the strobe is low.
- R3: With the device ready line held high, the strobe stays low for exactly T_PULSE cycles (default 7), and never for fewer.
- R4: During a write strobe the output enable is high and the data bus carries the request word. Both remain for T_WHOLD cycles (default 1) after the strobe rises, and then the enable drops. The enable is never high during a read strobe.
- R5: Chip selects and address stay valid for T_AHOLD cycles (default 1) after the strobe rises, and then both chip-select outputs return high.
- R6: While the synchronized ready line is low, the strobe is extended. The read word is captured at the clock edge where the strobe is released, so data that the device changes while the line is low is still returned.
- R7: If the ready line stays low until T_STALL_MAX cycles (default 130) have passed after the minimum strobe width, the strobe is released and done is given with the error flag set. The error flag is low on every transfer that completes normally.
- R8: Two consecutive strobe falling edges are at least T_CYCLE cycles apart (default 12). A strobe rising edge and the next falling edge are at least T_RECOV cycles apart (default 3).
- R9: Done is a single-cycle pulse. For a read it comes with the captured word on the read data output. The request port is not ready while a strobe is active.
- R10: A read uses only the read strobe and a write uses only the write strobe. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Engine accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select pair, active high (bus pins are inverted) |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Ready-line timeout, valid with done |
| rsp_rdata | output | 16 | Captured read word, valid with done |
| ata_cs_n | output | 2 | Bus chip selects, active low |
| ata_da | output | 3 | Bus address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus value driven by the host |
| ata_dd_oe | output | 1 | Host data bus output enable |
| ata_dd_in | input | 16 | Data bus value from the device |
| ata_iordy | input | 1 | Device ready; low stretches the strobe |

## Verification
Two events can meet in one cycle: the minimum pulse width running out and the synchronized ready line returning high. A short stall that ends inside the minimum width checks the first case, because the strobe must still be exactly T_PULSE cycles long. A long stall checks the second case: the bench changes the device data in the same step that it raises the ready line, and the returned word must be the late value, which shows that the release and the capture happen on the same edge. A second pair is the done pulse of one transfer and the acceptance of the next. Requests issued back to back are judged on the measured spacing between strobe edges.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } pio_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/ata_pio_gap.sv
module ata_pio_gap #(
    parameter int T_RECOV = 3,
    parameter int T_CYCLE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_start,
    input  logic strobe_end,
    output logic gap_ready
);

    localparam int RW = $clog2(T_RECOV + 1);
    localparam int FW = $clog2(T_CYCLE + 1);

    typedef struct packed {
        logic [RW-1:0] rec;
        logic [FW-1:0] flr;
    } gap_t;

    gap_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (g_q.rec != '0) g_d.rec = g_q.rec - 1'b1;
        if (g_q.flr != '0) g_d.flr = g_q.flr - 1'b1;
        if (strobe_end)   g_d.rec = RW'(T_RECOV);
        if (strobe_start) g_d.flr = FW'(T_CYCLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gap_ready = (g_q.rec == '0) && (g_q.flr == '0);

    // R8: recovery window closes the request port right after a strobe ends
    a_r8_blocked_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_end |=> !gap_ready);

endmodule

// File: rtl/ata_pio_host.sv
module ata_pio_host
    import ata_pio_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 3,
    parameter int T_ASETUP    = 3,
    parameter int T_PULSE     = 7,
    parameter int T_RECOV     = 3,
    parameter int T_CYCLE     = 12,
    parameter int T_WHOLD     = 1,
    parameter int T_AHOLD     = 1,
    parameter int T_STALL_MAX = 130,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_cs,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic [1:0]    ata_cs_n,
    output logic [AW-1:0] ata_da,
    output logic          ata_dior_n,
    output logic          ata_diow_n,
    output logic [DW-1:0] ata_dd_out,
    output logic          ata_dd_oe,
    input  logic [DW-1:0] ata_dd_in,
    input  logic          ata_iordy
);

    localparam int CNT_MAX = imax(imax(T_ASETUP, T_PULSE), imax(T_AHOLD, T_WHOLD));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int TW      = $clog2(T_STALL_MAX + 1);

    typedef struct packed {
        pio_state_e    st;
        logic          wr;
        logic [1:0]    cs_n;
        logic [AW-1:0] da;
        logic [DW-1:0] dd;
        logic          oe;
        logic          rd_n;
        logic          wr_n;
        logic [CW-1:0] cnt;
        logic [TW-1:0] stall;
        logic          err_pend;
        logic          done;
        logic          err;
        logic [DW-1:0] rdata;
    } eng_t;

    localparam eng_t ENG_RST = '{
        st: ST_IDLE, wr: 1'b0, cs_n: 2'b11, da: '0, dd: '0, oe: 1'b0,
        rd_n: 1'b1, wr_n: 1'b1, cnt: '0, stall: '0, err_pend: 1'b0,
        done: 1'b0, err: 1'b0, rdata: '0
    };

    eng_t s_q, s_d;
    logic iordy_s;
    logic gap_ready;
    logic accept;
    logic strobe_start;
    logic strobe_end;

    ata_pio_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ata_iordy),
        .q_out (iordy_s)
    );

    ata_pio_gap #(
        .T_RECOV (T_RECOV),
        .T_CYCLE (T_CYCLE)
    ) i_gap (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_start (strobe_start),
        .strobe_end   (strobe_end),
        .gap_ready    (gap_ready)
    );

    assign req_ready = (s_q.st == ST_IDLE) && gap_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.st       = ST_SETUP;
                    s_d.wr       = req_write;
                    s_d.cs_n     = ~req_cs;
                    s_d.da       = req_addr;
                    s_d.dd       = req_wdata;
                    s_d.oe       = req_write;
                    s_d.err_pend = 1'b0;
                    s_d.cnt      = CW'(T_ASETUP - 1);
                end
            end
            ST_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_STROBE;
                    s_d.rd_n  = s_q.wr;
                    s_d.wr_n  = ~s_q.wr;
                    s_d.cnt   = CW'(T_PULSE - 1);
                    s_d.stall = '0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (iordy_s || (s_q.stall == TW'(T_STALL_MAX - 1))) begin
                    s_d.st       = ST_HOLD;
                    s_d.rd_n     = 1'b1;
                    s_d.wr_n     = 1'b1;
                    s_d.cnt      = '0;
                    s_d.err_pend = ~iordy_s;
                    if (!s_q.wr) s_d.rdata = ata_dd_in;
                end else begin
                    s_d.stall = s_q.stall + 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt == CW'(T_WHOLD - 1)) s_d.oe = 1'b0;
                if (s_q.cnt == CW'(T_AHOLD - 1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.cs_n = 2'b11;
                    s_d.da   = '0;
                    s_d.oe   = 1'b0;
                    s_d.done = 1'b1;
                    s_d.err  = s_q.err_pend;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = ENG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ENG_RST;
        else        s_q <= s_d;
    end

    assign strobe_start = (s_q.st == ST_SETUP) && (s_q.cnt == '0);
    assign strobe_end   = (s_q.st == ST_STROBE) && (s_d.st == ST_HOLD);

    assign ata_cs_n   = s_q.cs_n;
    assign ata_da     = s_q.da;
    assign ata_dior_n = s_q.rd_n;
    assign ata_diow_n = s_q.wr_n;
    assign ata_dd_out = s_q.dd;
    assign ata_dd_oe  = s_q.oe;
    assign rsp_done   = s_q.done;
    assign rsp_err    = s_q.err;
    assign rsp_rdata  = s_q.rdata;

    // R10: never both strobes active
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ata_dior_n, ~ata_diow_n}));

    // R4: host does not drive the bus during a read strobe
    a_r4_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_dior_n |-> !ata_dd_oe);

    // R2: address and chip selects frozen while a strobe stays low
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_dior_n || !ata_diow_n) |=>
            ((ata_dior_n && ata_diow_n) || ($stable(ata_da) && $stable(ata_cs_n))));

    // R6: a low synchronized ready line keeps the strobe active
    a_r6_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STROBE && s_q.cnt == '0 && !iordy_s &&
         s_q.stall != TW'(T_STALL_MAX - 1)) |=> (!ata_dior_n || !ata_diow_n));

    // R7: error only accompanies done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9: port closed while a strobe is active
    a_r9_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_dior_n || !ata_diow_n) |-> !req_ready);

endmodule

// File: tb/test_ata_pio_host.sv
module test_ata_pio_host;

    localparam int T_AS  = 3;
    localparam int T_PW  = 7;
    localparam int T_REC = 3;
    localparam int T_CYC = 12;
    localparam int T_WH  = 1;
    localparam int T_AH  = 1;
    localparam int T_TMO = 130;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = 2'b00;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;
    logic        ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [15:0] ata_dd_out;
    logic [15:0] ata_dd_in = 16'h0000;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ata_pio_host i_ata_pio_host (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ata_cs_n(ata_cs_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
        .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
    );

    // bus monitor and device model, all at the falling clock edge
    int cyc = 0;
    int t_addr, t_fall, t_rise, t_csoff, t_oeoff, prev_fall, prev_rise;
    bit prev_strobe = 0, prev_oe = 0;
    logic [1:0] prev_cs = 2'b11;
    bit wr_ok, rd_oe_bad, ready_bad, both_bad, oe_at_rise, wrong_strobe;
    bit exp_write;
    logic [15:0] exp_wdata;
    logic [2:0]  exp_addr;
    int stall_req = 0;       // 0 none, >0 cycles, -1 forever
    int stall_left = 0;
    bit stall_forever = 0;
    logic [15:0] late_val = '0;

    always @(negedge clk) begin
        bit strobe;
        cyc++;
        strobe = !ata_dior_n || !ata_diow_n;
        if (ata_cs_n != 2'b11 && prev_cs == 2'b11) t_addr = cyc;
        if (strobe && !prev_strobe) begin
            prev_fall = t_fall;
            prev_rise = t_rise;
            t_fall    = cyc;
            wr_ok     = 1;
            if (exp_write ? ata_diow_n : ata_dior_n) wrong_strobe = 1;
            if (stall_req > 0) begin
                ata_iordy  = 1'b0;
                stall_left = stall_req;
            end else if (stall_req < 0) begin
                ata_iordy     = 1'b0;
                stall_forever = 1;
            end
        end else if (stall_left > 0) begin
            stall_left--;
            if (stall_left == 0) begin
                ata_iordy = 1'b1;
                ata_dd_in = late_val;
            end
        end
        if (strobe && !ata_diow_n &&
            (!ata_dd_oe || ata_dd_out != exp_wdata || ata_da != exp_addr)) wr_ok = 0;
        if (!ata_dior_n && ata_dd_oe) rd_oe_bad = 1;
        if (strobe && req_ready) ready_bad = 1;
        if (!ata_dior_n && !ata_diow_n) both_bad = 1;
        if (!strobe && prev_strobe) begin
            t_rise     = cyc;
            oe_at_rise = ata_dd_oe && (ata_dd_out == exp_wdata);
            if (stall_forever) begin
                stall_forever = 0;
                ata_iordy     = 1'b1;
            end
        end
        if (ata_cs_n == 2'b11 && prev_cs != 2'b11) t_csoff = cyc;
        if (!ata_dd_oe && prev_oe) t_oeoff = cyc;
        prev_cs     = ata_cs_n;
        prev_strobe = strobe;
        prev_oe     = ata_dd_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [15:0] got_rd;
    bit          got_err;

    task automatic xfer(input bit wr, input logic [1:0] cs, input logic [2:0] a,
                        input logic [15:0] wd);
        @(negedge clk);
        exp_write = wr; exp_wdata = wd; exp_addr = a;
        req_valid = 1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_done) @(negedge clk);
        got_rd  = rsp_rdata;
        got_err = rsp_err;
        @(negedge clk);
        chk(!rsp_done, "R9 done single cycle", rsp_done, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(ata_dior_n && ata_diow_n, "R1 strobes high", {ata_dior_n, ata_diow_n}, 3);
        chk(ata_cs_n == 2'b11, "R1 cs high", ata_cs_n, 3);
        chk(!ata_dd_oe, "R1 oe low", ata_dd_oe, 0);
        chk(!rsp_done, "R1 done low", rsp_done, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
    endtask

    task automatic t_write;
        xfer(1, 2'b01, 3'd5, 16'hA5C3);
        chk(t_fall - t_addr == T_AS, "R2 setup", t_fall - t_addr, T_AS);
        chk(t_rise - t_fall == T_PW, "R3 width", t_rise - t_fall, T_PW);
        chk(wr_ok, "R4 write data during strobe", wr_ok, 1);
        chk(oe_at_rise, "R4 data held at rise", oe_at_rise, 1);
        chk(t_oeoff - t_rise == T_WH, "R4 oe release", t_oeoff - t_rise, T_WH);
        chk(t_csoff - t_rise == T_AH, "R5 addr hold", t_csoff - t_rise, T_AH);
        chk(!got_err, "R7 no err", got_err, 0);
        chk(!wrong_strobe, "R10 write strobe", wrong_strobe, 0);
    endtask

    task automatic t_read;
        ata_dd_in = 16'h1234;
        xfer(0, 2'b10, 3'd7, 16'h0);
        chk(got_rd == 16'h1234, "R9 read data", got_rd, 16'h1234);
        chk(t_rise - t_fall == T_PW, "R3 read width", t_rise - t_fall, T_PW);
        chk(!rd_oe_bad, "R4 no drive on read", rd_oe_bad, 0);
        chk(!wrong_strobe, "R10 read strobe", wrong_strobe, 0);
        chk(t_fall - t_addr == T_AS, "R2 read setup", t_fall - t_addr, T_AS);
    endtask

    task automatic t_short_stall;
        stall_req = 2;
        ata_dd_in = 16'h0F0F;
        late_val  = 16'h0F0F;
        xfer(0, 2'b01, 3'd1, 16'h0);
        stall_req = 0;
        chk(t_rise - t_fall == T_PW, "R6 short stall width", t_rise - t_fall, T_PW);
        chk(got_rd == 16'h0F0F, "R6 short stall data", got_rd, 16'h0F0F);
    endtask

    task automatic t_long_stall;
        stall_req = 20;
        ata_dd_in = 16'hDEAD;
        late_val  = 16'hBEEF;
        xfer(0, 2'b01, 3'd0, 16'h0);
        stall_req = 0;
        chk(t_rise - t_fall >= 21 && t_rise - t_fall <= 25, "R6 stretched width",
            t_rise - t_fall, 23);
        chk(got_rd == 16'hBEEF, "R6 late data", got_rd, 16'hBEEF);
        chk(!got_err, "R7 stall no err", got_err, 0);
    endtask

    task automatic t_timeout;
        stall_req = -1;
        ata_dd_in = 16'h5555;
        xfer(0, 2'b10, 3'd2, 16'h0);
        stall_req = 0;
        chk(got_err, "R7 timeout err", got_err, 1);
        chk(t_rise - t_fall >= T_PW + T_TMO - 3 && t_rise - t_fall <= T_PW + T_TMO + 1,
            "R7 timeout width", t_rise - t_fall, T_PW + T_TMO - 1);
        ata_dd_in = 16'h7777;
        xfer(0, 2'b10, 3'd3, 16'h0);
        chk(!got_err && got_rd == 16'h7777, "R7 recovery after timeout", got_rd, 16'h7777);
    endtask

    task automatic t_back_to_back;
        xfer(1, 2'b01, 3'd4, 16'h1111);
        xfer(1, 2'b01, 3'd6, 16'h2222);
        chk(t_fall - prev_fall >= T_CYC, "R8 cycle floor", t_fall - prev_fall, T_CYC);
        chk(t_fall - prev_rise >= T_REC, "R8 recovery", t_fall - prev_rise, T_REC);
        chk(wr_ok, "R4 second write data", wr_ok, 1);
        chk(!ready_bad, "R9 closed while strobing", ready_bad, 0);
        chk(!both_bad, "R10 never both", both_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read();
        t_short_stall();
        t_long_stall();
        t_timeout();
        t_back_to_back();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule